// File: doc/BRIEF.md
# Glitch-free system clock switcher

This block picks the system clock from three free-running sources: a primary external clock, an internal oscillator clock and a slow 32.768 kHz secondary clock. Software chooses the source through a 2-bit select field, written through a one-cycle write strobe. A separate override port lets automatic hardware, such as fail-safe monitoring or two-speed start-up, force a different source. The override does not disturb the software field.

Each source has its own enable chain. This chain opens and closes the source's gate only while that source is low. A control state machine, clocked by an always-running control clock, sequences every change as break-before-make:

- It first withdraws the running source.
- It waits until it sees that source's gate closed.
- It then requests the new source.
- It waits until that source's gate is seen open.

The output clock therefore holds low across the gap and never shows a shortened phase.

Three status flags report which source actually drives the output. These flags are independent of the select field. A switch towards a source whose stable input is low waits until that input rises. A select value written during a switch is kept in the field and applied once the running switch finishes. The stable inputs and control pins are plain levels in the control clock domain. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `sysclk_switch`

## Requirements
- R1: Select code 00 chooses the primary clock, 01 the secondary clock and 10 the internal clock. After the switch settles, the output period equals the chosen source's period.
- R2: A write strobe loads the select field on the next control clock edge. Reset clears the field to 00.
- R3: During a switch the output stays low for at least two periods of the incoming clock and at most three incoming periods plus five control periods. This is measured from the last outgoing pulse to the first incoming pulse.
- R4: Every high phase of the output equals a half period of one of the sources, and no low phase is shorter than the shortest half period.
- R5: At most one running flag is high. Once settled, the flag for the source that drives the output is the one set: bit order sec, int, pri maps to flags run_sec, run_int, run_pri.
- R6: While the override enable is high, the override code replaces the select field as the target, using the same encoding as R1. The select field is left unchanged. When the override is released, the block returns to the source in the select field.
- R7: After reset no source drives the output, and every running flag stays low, until the stable input of the target is high. The primary running flag rises only after the primary stable input is high.
- R8: Code 11 selects the internal clock. Changing the code between 10 and 11 causes no switch and no gap.
- R9: While the target's stable input is low, the current source keeps running and busy stays low.
- R10: A select value written while busy is high is applied after the running switch completes.
- R11: Busy is high from the start of a switch to its completion. The running flags change only while busy is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ctl_clk | input | 1 | Always-running control clock |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| clk_pri | input | 1 | Primary external clock source |
| clk_int | input | 1 | Internal oscillator clock source |
| clk_sec | input | 1 | Secondary 32.768 kHz clock source |
| stable_pri | input | 1 | Primary source ready (start-up timer expired) |
| stable_int | input | 1 | Internal source ready |
| stable_sec | input | 1 | Secondary source ready |
| wr_en | input | 1 | Write strobe for the select field |
| wr_sel | input | 2 | Value written to the select field |
| ovr_en | input | 1 | Hardware override active |
| ovr_sel | input | 2 | Source code forced by the override |
| sel_q | output | 2 | Software select field |
| run_pri | output | 1 | Primary clock drives the output |
| run_int | output | 1 | Internal clock drives the output |
| run_sec | output | 1 | Secondary clock drives the output |
| busy | output | 1 | A switch is in progress |
| clk_out | output | 1 | Glitch-free system clock |

## Verification
The bench sweeps every ordered pair of select codes. It measures the output high and low phases against the source half periods, so a gate that changes while its source is high shows up as a runt phase. It also bounds the longest low gap, so a make-before-break order or a missing handshake stage is caught.

Further checks cover the following faults:
- Mapping code 11 to anything but the internal clock gives a wrong period, or an unwanted gap between 10 and 11.
- An override that writes the select field is seen by reading that field back.
- A switch that ignores the stable input would drop the running source while the target is not ready.
- A select written mid-switch that is lost leaves the output on the intermediate source.

// File: rtl/sysclk_pkg.sv
`timescale 1ns/1ps
package sysclk_pkg;
  localparam int NSRC    = 3;
  localparam int SRC_W   = $clog2(NSRC);
  localparam logic [SRC_W-1:0] SRC_PRI = 2'd0;
  localparam logic [SRC_W-1:0] SRC_INT = 2'd1;
  localparam logic [SRC_W-1:0] SRC_SEC = 2'd2;

  typedef logic [SRC_W-1:0] src_idx_t;

  typedef enum logic [1:0] {
    ST_START,
    ST_IDLE,
    ST_DROP,
    ST_RAISE
  } sw_state_e;

  // Software code to source index: 00 primary, 01 secondary, 1x internal.
  function automatic src_idx_t sel_to_src(input logic [1:0] code);
    case (code)
      2'b00:   return SRC_PRI;
      2'b01:   return SRC_SEC;
      default: return SRC_INT;
    endcase
  endfunction
endpackage

// File: rtl/sysclk_sync.sv
`timescale 1ns/1ps
module sysclk_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int TOT = STAGES * W;

  logic [TOT-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[TOT-W-1:0], d};
  end

  assign q = shreg[TOT-1 -: W];
endmodule

// File: rtl/sysclk_gate_chain.sv
`timescale 1ns/1ps
module sysclk_gate_chain #(
  parameter int STAGES = 2
) (
  input  logic clk_src,
  input  logic rst_n,
  input  logic req,
  output logic gate,
  output logic clk_gated
);
  logic [STAGES-1:0] pipe;

  // Resynchronise the request into the source domain.
  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-2:0], req};
  end

  // Gate moves only on the falling edge, while the source is low.
  always_ff @(negedge clk_src or negedge rst_n) begin
    if (!rst_n) gate <= 1'b0;
    else        gate <= pipe[STAGES-1];
  end

  assign clk_gated = clk_src & gate;
endmodule

// File: rtl/sysclk_switch_ctl.sv
`timescale 1ns/1ps
module sysclk_switch_ctl
  import sysclk_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  src_idx_t        tgt_src,
  input  logic [NSRC-1:0] stable,
  input  logic [NSRC-1:0] ack,
  output logic [NSRC-1:0] req,
  output logic            busy
);
  sw_state_e state;
  src_idx_t  cur;
  src_idx_t  nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_START;
      cur   <= SRC_PRI;
      nxt   <= SRC_PRI;
      req   <= '0;
    end else begin
      case (state)
        ST_START: begin
          if (stable[tgt_src]) begin
            nxt          <= tgt_src;
            req[tgt_src] <= 1'b1;
            state        <= ST_RAISE;
          end
        end
        ST_IDLE: begin
          if (tgt_src != cur && stable[tgt_src]) begin
            nxt      <= tgt_src;
            req[cur] <= 1'b0;
            state    <= ST_DROP;
          end
        end
        ST_DROP: begin
          if (!ack[cur]) begin
            req[nxt] <= 1'b1;
            state    <= ST_RAISE;
          end
        end
        ST_RAISE: begin
          if (ack[nxt]) begin
            cur   <= nxt;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_START;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/sysclk_switch.sv
`timescale 1ns/1ps
module sysclk_switch
  import sysclk_pkg::*;
#(
  parameter int GATE_STAGES = 2,
  parameter int ACK_STAGES  = 2
) (
  input  logic       ctl_clk,
  input  logic       rst_n,
  input  logic       clk_pri,
  input  logic       clk_int,
  input  logic       clk_sec,
  input  logic       stable_pri,
  input  logic       stable_int,
  input  logic       stable_sec,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic       ovr_en,
  input  logic [1:0] ovr_sel,
  output logic [1:0] sel_q,
  output logic       run_pri,
  output logic       run_int,
  output logic       run_sec,
  output logic       busy,
  output logic       clk_out
);
  logic [NSRC-1:0] src_clk;
  logic [NSRC-1:0] stable_vec;
  logic [NSRC-1:0] req;
  logic [NSRC-1:0] gate;
  logic [NSRC-1:0] gated;
  logic [NSRC-1:0] ack;
  logic [1:0]      eff_code;
  src_idx_t        tgt_src;

  assign src_clk    = {clk_sec, clk_int, clk_pri};
  assign stable_vec = {stable_sec, stable_int, stable_pri};

  // Software select field; only the write port changes it.
  always_ff @(posedge ctl_clk or negedge rst_n) begin
    if (!rst_n)     sel_q <= 2'b00;
    else if (wr_en) sel_q <= wr_sel;
  end

  assign eff_code = ovr_en ? ovr_sel : sel_q;
  assign tgt_src  = sel_to_src(eff_code);

  sysclk_switch_ctl u_ctl (
    .clk     (ctl_clk),
    .rst_n   (rst_n),
    .tgt_src (tgt_src),
    .stable  (stable_vec),
    .ack     (ack),
    .req     (req),
    .busy    (busy)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    sysclk_gate_chain #(.STAGES(GATE_STAGES)) u_chain (
      .clk_src   (src_clk[i]),
      .rst_n     (rst_n),
      .req       (req[i]),
      .gate      (gate[i]),
      .clk_gated (gated[i])
    );
  end

  sysclk_sync #(.STAGES(ACK_STAGES), .W(NSRC)) u_ack_sync (
    .clk   (ctl_clk),
    .rst_n (rst_n),
    .d     (gate),
    .q     (ack)
  );

  assign clk_out = |gated;
  assign run_pri = ack[SRC_PRI];
  assign run_int = ack[SRC_INT];
  assign run_sec = ack[SRC_SEC];
endmodule

// File: rtl/sysclk_switch_chk.sv
`timescale 1ns/1ps
module sysclk_switch_chk
  import sysclk_pkg::*;
(
  input logic       ctl_clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_sel,
  input logic [1:0] sel_q,
  input logic       ovr_en,
  input logic [1:0] ovr_sel,
  input logic       stable_pri,
  input logic       stable_int,
  input logic       stable_sec,
  input logic       run_pri,
  input logic       run_int,
  input logic       run_sec,
  input logic       busy
);
  src_idx_t want;
  logic     want_ready;

  assign want = sel_to_src(ovr_en ? ovr_sel : sel_q);

  always_comb begin
    case (want)
      SRC_PRI: want_ready = stable_pri;
      SRC_SEC: want_ready = stable_sec;
      default: want_ready = stable_int;
    endcase
  end

  p_write_load_r2: assert property (@(posedge ctl_clk) disable iff (!rst_n)
    wr_en |=> (sel_q == $past(wr_sel)));

  p_field_hold_r6: assert property (@(posedge ctl_clk) disable iff (!rst_n)
    !wr_en |=> $stable(sel_q));

  p_single_run_r5: assert property (@(posedge ctl_clk) disable iff (!rst_n)
    $onehot0({run_sec, run_int, run_pri}));

  p_pending_idle_r9: assert property (@(posedge ctl_clk) disable iff (!rst_n)
    (!busy && !want_ready) |=> !busy);

  p_run_edge_busy_r11: assert property (@(posedge ctl_clk) disable iff (!rst_n)
    ($rose(run_pri) || $rose(run_int) || $rose(run_sec) ||
     $fell(run_pri) || $fell(run_int) || $fell(run_sec)) |-> busy);
endmodule

bind sysclk_switch sysclk_switch_chk u_chk (
  .ctl_clk    (ctl_clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .sel_q      (sel_q),
  .ovr_en     (ovr_en),
  .ovr_sel    (ovr_sel),
  .stable_pri (stable_pri),
  .stable_int (stable_int),
  .stable_sec (stable_sec),
  .run_pri    (run_pri),
  .run_int    (run_int),
  .run_sec    (run_sec),
  .busy       (busy)
);

// File: tb/sysclk_switch_test.sv
`timescale 1ns/1ps
module sysclk_switch_test;
  logic ctl_clk = 1'b0;
  logic clk_pri = 1'b0;
  logic clk_int = 1'b0;
  logic clk_sec = 1'b0;
  logic rst_n   = 1'b0;

  always #2  ctl_clk = ~ctl_clk;   // 250 MHz
  always #5  clk_pri = ~clk_pri;   // 10 ns
  always #3  clk_int = ~clk_int;   // 6 ns
  always #15 clk_sec = ~clk_sec;   // 30 ns

  logic       stable_pri = 1'b0, stable_int = 1'b1, stable_sec = 1'b1;
  logic       wr_en = 1'b0, ovr_en = 1'b0;
  logic [1:0] wr_sel = 2'b00, ovr_sel = 2'b00;
  logic [1:0] sel_q;
  logic       run_pri, run_int, run_sec, busy, clk_out;

  sysclk_switch uut (
    .ctl_clk(ctl_clk), .rst_n(rst_n), .clk_pri(clk_pri), .clk_int(clk_int),
    .clk_sec(clk_sec), .stable_pri(stable_pri), .stable_int(stable_int),
    .stable_sec(stable_sec), .wr_en(wr_en), .wr_sel(wr_sel), .ovr_en(ovr_en),
    .ovr_sel(ovr_sel), .sel_q(sel_q), .run_pri(run_pri), .run_int(run_int),
    .run_sec(run_sec), .busy(busy), .clk_out(clk_out)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // ---------------- output phase monitor (R3, R4) ----------------
  realtime t_r = 0, t_f = 0, mark_t = 0, seen_mark = 0, max_low = 0;
  int      runt_err = 0;
  int      rise_cnt = 0;
  logic    mon_on = 1'b0;

  function automatic bit near(realtime a, realtime b);
    return (a - b < 0.01) && (b - a < 0.01);
  endfunction

  always @(posedge clk_out) begin
    realtime lo;
    rise_cnt++;
    if (seen_mark != mark_t) begin
      max_low   = 0;
      seen_mark = mark_t;
    end
    if (mon_on && t_f > 0) begin
      lo = $realtime - t_f;
      if (lo > max_low) max_low = lo;
      if (lo < 2.99) runt_err++;
    end
    t_r = $realtime;
  end

  always @(negedge clk_out) begin
    realtime hi;
    if (mon_on && t_r > 0) begin
      hi = $realtime - t_r;
      if (!(near(hi, 3.0) || near(hi, 5.0) || near(hi, 15.0))) runt_err++;
    end
    t_f = $realtime;
  end

  // ---------------- helpers ----------------
  function automatic int src_of(input logic [1:0] code);
    if (code == 2'b00) return 0;
    if (code == 2'b01) return 2;
    return 1;
  endfunction

  function automatic realtime per_of(input int s);
    if (s == 0) return 10.0;
    if (s == 1) return 6.0;
    return 30.0;
  endfunction

  task automatic do_write(input logic [1:0] v);
    @(negedge ctl_clk);
    wr_en  = 1'b1;
    wr_sel = v;
    @(negedge ctl_clk);
    wr_en  = 1'b0;
  endtask

  // Wait until busy has stayed low for eight control cycles.
  task automatic settle();
    int quiet = 0;
    repeat (4) @(negedge ctl_clk);
    for (int n = 0; n < 4000 && quiet < 8; n++) begin
      @(negedge ctl_clk);
      if (busy) quiet = 0;
      else      quiet++;
    end
  endtask

  task automatic period(output realtime p);
    realtime a;
    @(posedge clk_out);
    @(posedge clk_out);
    a = $realtime;
    @(posedge clk_out);
    p = $realtime - a;
    @(negedge ctl_clk);
  endtask

  task automatic expect_src(input int s, input string rq);
    realtime p;
    logic [2:0] exp_run;
    exp_run = 3'b001 << s;
    chk({run_sec, run_int, run_pri} == exp_run, rq, "run flags",
        int'({run_sec, run_int, run_pri}), int'(exp_run));
    period(p);
    chk(near(p, per_of(s)), rq, "output period ps",
        int'(p * 1000.0), int'(per_of(s) * 1000.0));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge ctl_clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    realtime    p;
    logic [1:0] v;
    int         r0;

    repeat (5) @(negedge ctl_clk);
    rst_n  = 1'b1;
    mon_on = 1'b1;
    r0 = rise_cnt;
    repeat (60) @(negedge ctl_clk);
    // R2: reset value of the field; R7: nothing runs before primary is ready
    chk(sel_q == 2'b00, "R2", "sel_q after reset", int'(sel_q), 0);
    chk({run_sec, run_int, run_pri} == 3'b000, "R7", "run flags before stable",
        int'({run_sec, run_int, run_pri}), 0);
    chk(rise_cnt == r0, "R7", "output edges before stable", rise_cnt - r0, 0);
    chk(busy == 1'b1, "R11", "busy while waiting for first source", int'(busy), 1);
    stable_pri = 1'b1;
    settle();
    expect_src(0, "R7");

    // Sweep every ordered pair of select codes: R1, R3, R4, R5, R8
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        int sa, sb;
        sa = src_of(2'(a));
        sb = src_of(2'(b));
        do_write(2'(a));
        settle();
        mark_t = $realtime;
        do_write(2'(b));
        chk(sel_q == 2'(b), "R2", "sel_q readback", int'(sel_q), b);
        settle();
        expect_src(sb, (b == 3) ? "R8" : "R1");
        chk(runt_err == 0, "R4", "runt phases", runt_err, 0);
        if (sa != sb) begin
          chk(max_low >= 2.0 * per_of(sb) - 0.01, "R3", "gap lower bound ps",
              int'(max_low * 1000.0), int'(2000.0 * per_of(sb)));
          chk(max_low <= 3.0 * per_of(sb) + 20.01, "R3", "gap upper bound ps",
              int'(max_low * 1000.0), int'(1000.0 * (3.0 * per_of(sb) + 20.0)));
        end else begin
          chk(max_low <= per_of(sb) / 2.0 + 0.01, "R8", "no gap without switch ps",
              int'(max_low * 1000.0), int'(500.0 * per_of(sb)));
        end
      end
    end

    // R6: override to internal then secondary, field untouched
    do_write(2'b00);
    settle();
    ovr_sel = 2'b10;
    ovr_en  = 1'b1;
    settle();
    expect_src(1, "R6");
    chk(sel_q == 2'b00, "R6", "sel_q under override", int'(sel_q), 0);
    ovr_sel = 2'b01;
    settle();
    expect_src(2, "R6");
    chk(sel_q == 2'b00, "R6", "sel_q under override", int'(sel_q), 0);
    ovr_en = 1'b0;
    settle();
    expect_src(0, "R6");

    // R9: target not stable keeps current source, busy low
    stable_sec = 1'b0;
    do_write(2'b01);
    repeat (200) @(negedge ctl_clk);
    chk(busy == 1'b0, "R9", "busy while target not ready", int'(busy), 0);
    expect_src(0, "R9");
    stable_sec = 1'b1;
    settle();
    expect_src(2, "R9");

    // R10: write during a switch is applied afterwards
    do_write(2'b00);
    settle();
    do_write(2'b10);
    repeat (3) @(negedge ctl_clk);
    chk(busy == 1'b1, "R11", "busy during switch", int'(busy), 1);
    v = 2'b01;
    do_write(v);
    chk(busy == 1'b1, "R10", "write landed during switch", int'(busy), 1);
    settle();
    chk(sel_q == v, "R10", "sel_q after late write", int'(sel_q), int'(v));
    expect_src(2, "R10");
    period(p);
    chk(runt_err == 0, "R4", "runt phases final", runt_err, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule